// File: doc/BRIEF.md
# Serial Command Sample Timer

This block is the serial front end of a sampling converter. A host frames each command with an active-low chip select and shifts bits in MSB first on the rising edges of a serial clock. The block runs entirely in its system clock domain. It brings the serial clock, chip select and data in through two-flop synchronizers and works on detected serial-clock rising edges. Once the fourth bit of a frame has arrived, it decodes the 4-bit command. If the command selects an analog input or a test input, it latches the code as the active channel and opens a sampling window that lasts a programmable number of serial-clock edges.

When the window closes, the block issues a one-cycle convert-start strobe and enters a conversion phase. In this phase it emits single-cycle conversion-clock enables. The enables come from one of four sources: an externally supplied oscillator tick, every serial-clock edge, every second edge or every fourth edge. After twelve enables it raises a done pulse and returns to idle. If chip select rises before all sixteen frame bits have arrived, the decode is abandoned and any open sampling window is closed.

Top module: `cmd_sample_timer`

## Requirements
- R1: After reset, sampleActive, convStart, convBusy, convClkEn and convDone are all 0 and channel is 0.
- R2: Data is taken on each synchronized rising sclk edge while csN is low, MSB first. On the 4th such edge of a frame, a command code of 0x0 to 0x7 (analog channel) or 0xB, 0xC or 0xD (test input) raises sampleActive and loads channel with that code.
- R3: Any other 4-bit code (0x8, 0x9, 0xA, 0xE, 0xF) opens no sampling window and produces no convStart.
- R4: With longSample = 0, the window spans 12 rising sclk edges, so convStart fires on rising edge 16 of the frame.
- R5: With longSample = 1, the window spans 24 rising sclk edges, so convStart fires on rising edge 28. Chip select rising after a complete 16-bit frame does not cut the window short.
- R6: convStart is one system clock wide, and from the next cycle on convBusy is 1 and sampleActive is 0.
- R7: clkSrc = 2'b01 gives one convClkEn per rising sclk edge during conversion, so convDone follows 12 edges after convStart.
- R8: clkSrc = 2'b10 gives one convClkEn per fourth rising sclk edge, so convDone follows 48 edges after convStart.
- R9: clkSrc = 2'b11 gives one convClkEn per second rising sclk edge, so convDone follows 24 edges after convStart.
- R10: clkSrc = 2'b00 passes oscTick through as convClkEn during conversion.
- R11: Exactly 12 convClkEn pulses occur per conversion. convClkEn is only asserted while convBusy is 1. convDone is a single pulse in the cycle after the 12th enable, and it leaves convBusy at 0.
- R12: csN rising before 16 bits of a frame have arrived closes an open sampling window, and no convStart follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock, asynchronous to clk |
| csN | input | 1 | Active-low frame select |
| sdi | input | 1 | Serial command data, MSB first |
| longSample | input | 1 | 0: 12-edge window, 1: 24-edge window |
| clkSrc | input | 2 | Conversion clock source: 00 oscillator, 01 sclk, 10 sclk/4, 11 sclk/2 |
| oscTick | input | 1 | Single-cycle tick from the internal oscillator |
| channel | output | 4 | Latched command code of the current conversion |
| sampleActive | output | 1 | High while the sampling window is open |
| convStart | output | 1 | One-cycle strobe when the window closes |
| convBusy | output | 1 | High during the conversion phase |
| convClkEn | output | 1 | Single-cycle conversion-clock enable |
| convDone | output | 1 | One-cycle pulse after the final conversion tick |

## Verification
The bench uses the default parameters: a 16-bit frame, windows of 12 and 24 edges, and 12 conversion ticks. It sweeps all sixteen command codes. Each conversion code is run against both window lengths and all four clock sources, so every decode outcome and every edge count from window start to done can be checked. The serial clock runs at eight system cycles per period, which leaves room for the synchronizer delay. As a result, each strobe can be credited to the exact serial edge that caused it. One extra frame raises chip select after eight bits to exercise the abort path.

// File: rtl/cst_pkg.sv
package cst_pkg;

  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_SAMPLE = 2'd1,
    ST_CONV   = 2'd2
  } cst_state_t;

  // Strobes issued by the control towards the datapath
  typedef struct packed {
    logic loadCmd;
    logic sampleStep;
    logic startConv;
    logic divStep;
    logic convTick;
    logic finish;
  } cst_strobe_t;

  function automatic logic isConvCmd(input logic [CMD_W-1:0] code);
    return (code <= 4'd7) || (code >= 4'd11 && code <= 4'd13);
  endfunction

endpackage

// File: rtl/cst_datapath.sv
module cst_datapath
  import cst_pkg::*;
#(
  parameter int FRAME_BITS = 16,
  parameter int SAMPLE_W   = 5,
  parameter int TICK_W     = 4
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    sclk,
  input  logic                    csN,
  input  logic                    sdi,
  input  cst_strobe_t             ctl,
  output logic                    sclkRise,
  output logic                    csRise,
  output logic                    cmdEdge,
  output logic                    frameFull,
  output logic [CMD_W-1:0]        nextCmd,
  output logic [SAMPLE_W-1:0]     sampleCnt,
  output logic [1:0]              divCnt,
  output logic [TICK_W-1:0]       tickCnt,
  output logic [CMD_W-1:0]        channel
);

  localparam int BIT_W = $clog2(FRAME_BITS + 1);

  logic [2:0]       sclkSync;
  logic [2:0]       csSync;
  logic [1:0]       sdiSync;
  logic [BIT_W-1:0] bitCnt;
  logic [CMD_W-1:0] shiftReg;
  logic             bitEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkSync <= '0;
      csSync   <= '1;
      sdiSync  <= '0;
    end else begin
      sclkSync <= {sclkSync[1:0], sclk};
      csSync   <= {csSync[1:0], csN};
      sdiSync  <= {sdiSync[0], sdi};
    end
  end

  assign sclkRise  = sclkSync[1] & ~sclkSync[2];
  assign csRise    = csSync[1] & ~csSync[2];
  assign frameFull = (bitCnt == BIT_W'(FRAME_BITS));
  assign bitEdge   = sclkRise & ~csSync[1] & ~frameFull;
  assign cmdEdge   = bitEdge & (bitCnt == BIT_W'(CMD_W - 1));
  assign nextCmd   = {shiftReg[CMD_W-2:0], sdiSync[1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt   <= '0;
      shiftReg <= '0;
    end else if (csRise) begin
      bitCnt   <= '0;
    end else if (bitEdge) begin
      bitCnt   <= bitCnt + 1'b1;
      shiftReg <= nextCmd;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sampleCnt <= '0;
      channel   <= '0;
    end else if (ctl.loadCmd) begin
      sampleCnt <= '0;
      channel   <= nextCmd;
    end else if (ctl.sampleStep) begin
      sampleCnt <= sampleCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt  <= '0;
      tickCnt <= '0;
    end else if (ctl.startConv) begin
      divCnt  <= '0;
      tickCnt <= '0;
    end else begin
      if (ctl.divStep)  divCnt  <= divCnt + 1'b1;
      if (ctl.convTick) tickCnt <= tickCnt + 1'b1;
    end
  end

endmodule

// File: rtl/cst_control.sv
module cst_control
  import cst_pkg::*;
#(
  parameter int SHORT_SAMPLE = 12,
  parameter int LONG_SAMPLE  = 24,
  parameter int CONV_TICKS   = 12,
  parameter int SAMPLE_W     = 5,
  parameter int TICK_W       = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sclkRise,
  input  logic                csRise,
  input  logic                cmdEdge,
  input  logic                frameFull,
  input  logic [CMD_W-1:0]    nextCmd,
  input  logic [SAMPLE_W-1:0] sampleCnt,
  input  logic [1:0]          divCnt,
  input  logic [TICK_W-1:0]   tickCnt,
  input  logic                longSample,
  input  logic [1:0]          clkSrc,
  input  logic                oscTick,
  output cst_strobe_t         ctl,
  output cst_state_t          state,
  output logic                doneReg
);

  cst_state_t          nextState;
  logic [SAMPLE_W-1:0] sampleLast;
  logic                tick;

  assign sampleLast = longSample ? SAMPLE_W'(LONG_SAMPLE - 1) : SAMPLE_W'(SHORT_SAMPLE - 1);

  always_comb begin
    unique case (clkSrc)
      2'b00:   tick = oscTick;
      2'b01:   tick = sclkRise;
      2'b10:   tick = sclkRise & (divCnt == 2'd3);
      default: tick = sclkRise & divCnt[0];
    endcase
  end

  always_comb begin
    ctl       = '0;
    nextState = state;
    unique case (state)
      ST_IDLE: begin
        if (cmdEdge && isConvCmd(nextCmd)) begin
          ctl.loadCmd = 1'b1;
          nextState   = ST_SAMPLE;
        end
      end
      ST_SAMPLE: begin
        if (csRise && !frameFull) begin
          nextState = ST_IDLE;
        end else if (sclkRise) begin
          if (sampleCnt == sampleLast) begin
            ctl.startConv = 1'b1;
            nextState     = ST_CONV;
          end else begin
            ctl.sampleStep = 1'b1;
          end
        end
      end
      ST_CONV: begin
        ctl.divStep  = sclkRise;
        ctl.convTick = tick;
        if (tick && tickCnt == TICK_W'(CONV_TICKS - 1)) begin
          ctl.finish = 1'b1;
          nextState  = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      doneReg <= 1'b0;
    end else begin
      state   <= nextState;
      doneReg <= ctl.finish;
    end
  end

endmodule

// File: rtl/cmd_sample_timer.sv
module cmd_sample_timer
  import cst_pkg::*;
#(
  parameter int FRAME_BITS   = 16,
  parameter int SHORT_SAMPLE = 12,
  parameter int LONG_SAMPLE  = 24,
  parameter int CONV_TICKS   = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sclk,
  input  logic             csN,
  input  logic             sdi,
  input  logic             longSample,
  input  logic [1:0]       clkSrc,
  input  logic             oscTick,
  output logic [CMD_W-1:0] channel,
  output logic             sampleActive,
  output logic             convStart,
  output logic             convBusy,
  output logic             convClkEn,
  output logic             convDone
);

  localparam int SAMPLE_W = $clog2(LONG_SAMPLE);
  localparam int TICK_W   = $clog2(CONV_TICKS);

  cst_strobe_t         ctl;
  cst_state_t          state;
  logic                sclkRise, csRise, cmdEdge, frameFull;
  logic [CMD_W-1:0]    nextCmd;
  logic [SAMPLE_W-1:0] sampleCnt;
  logic [1:0]          divCnt;
  logic [TICK_W-1:0]   tickCnt;

  cst_datapath #(
    .FRAME_BITS(FRAME_BITS), .SAMPLE_W(SAMPLE_W), .TICK_W(TICK_W)
  ) uDatapath (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi), .ctl(ctl),
    .sclkRise(sclkRise), .csRise(csRise), .cmdEdge(cmdEdge), .frameFull(frameFull),
    .nextCmd(nextCmd), .sampleCnt(sampleCnt), .divCnt(divCnt), .tickCnt(tickCnt),
    .channel(channel)
  );

  cst_control #(
    .SHORT_SAMPLE(SHORT_SAMPLE), .LONG_SAMPLE(LONG_SAMPLE), .CONV_TICKS(CONV_TICKS),
    .SAMPLE_W(SAMPLE_W), .TICK_W(TICK_W)
  ) uControl (
    .clk(clk), .rstN(rstN), .sclkRise(sclkRise), .csRise(csRise), .cmdEdge(cmdEdge),
    .frameFull(frameFull), .nextCmd(nextCmd), .sampleCnt(sampleCnt), .divCnt(divCnt),
    .tickCnt(tickCnt), .longSample(longSample), .clkSrc(clkSrc), .oscTick(oscTick),
    .ctl(ctl), .state(state), .doneReg(convDone)
  );

  assign sampleActive = (state == ST_SAMPLE);
  assign convBusy     = (state == ST_CONV);
  assign convStart    = ctl.startConv;
  assign convClkEn    = ctl.convTick;

endmodule

// File: rtl/cst_checker.sv
module cst_checker
  import cst_pkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic [CMD_W-1:0] channel,
  input logic             sampleActive,
  input logic             convStart,
  input logic             convBusy,
  input logic             convClkEn,
  input logic             convDone
);

  assert_cmd_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sampleActive) |-> isConvCmd(channel));

  assert_start_handoff_R6: assert property (@(posedge clk) disable iff (!rstN)
    convStart |=> (convBusy && !sampleActive && !convStart));

  assert_phase_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({sampleActive, convBusy}));

  assert_enable_in_conv_R11: assert property (@(posedge clk) disable iff (!rstN)
    convClkEn |-> convBusy);

  assert_done_after_tick_R11: assert property (@(posedge clk) disable iff (!rstN)
    convDone |-> ($past(convClkEn) && !convBusy));

  assert_done_single_R11: assert property (@(posedge clk) disable iff (!rstN)
    convDone |=> !convDone);

endmodule

bind cmd_sample_timer cst_checker uChecker (
  .clk(clk), .rstN(rstN), .channel(channel), .sampleActive(sampleActive),
  .convStart(convStart), .convBusy(convBusy), .convClkEn(convClkEn), .convDone(convDone)
);

// File: tb/tb_cmd_sample_timer.sv
module tb_cmd_sample_timer;

  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sclk = 1'b0;
  logic       csN = 1'b1;
  logic       sdi = 1'b0;
  logic       longSample = 1'b0;
  logic [1:0] clkSrc = 2'b01;
  logic       oscTick = 1'b0;
  logic [3:0] channel;
  logic       sampleActive, convStart, convBusy, convClkEn, convDone;

  int total = 0;
  int bad = 0;
  int edgeIdx = 0;
  int startCnt, startEdge, tickSeen, doneCnt, doneEdge, sampleSeen, sampleEdge;

  always #5 clk = ~clk;

  cmd_sample_timer dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .sdi(sdi),
    .longSample(longSample), .clkSrc(clkSrc), .oscTick(oscTick),
    .channel(channel), .sampleActive(sampleActive), .convStart(convStart),
    .convBusy(convBusy), .convClkEn(convClkEn), .convDone(convDone)
  );

  // oscillator tick every 7 system cycles
  initial begin
    forever begin
      repeat (6) @(posedge clk);
      oscTick <= 1'b1;
      @(posedge clk);
      oscTick <= 1'b0;
    end
  end

  always @(negedge clk) begin
    if (rstN) begin
      if (convStart) begin startCnt++; startEdge = edgeIdx; end
      if (convClkEn) tickSeen++;
      if (convDone) begin doneCnt++; doneEdge = edgeIdx; end
      if (sampleActive && sampleSeen == 0) begin sampleSeen = 1; sampleEdge = edgeIdx; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit isConv(input int code);
    return (code < 8) || (code >= 11 && code <= 13);
  endfunction

  task automatic runFrame(input int code, input int lng, input int src, input int csAt,
                          input bit expectConv);
    logic [15:0] word;
    word = {code[3:0], 12'h5A3};
    startCnt = 0; startEdge = -1; tickSeen = 0; doneCnt = 0; doneEdge = -1;
    sampleSeen = 0; sampleEdge = -1; edgeIdx = 0;
    @(negedge clk);
    longSample = lng[0];
    clkSrc = src[1:0];
    csN = 1'b0;
    repeat (HALF) @(negedge clk);
    for (int i = 0; i < 100; i++) begin
      if (i == csAt) csN = 1'b1;
      sdi = (i < 16) ? word[15-i] : 1'b0;
      sclk = 1'b0;
      repeat (HALF) @(negedge clk);
      sclk = 1'b1;
      edgeIdx++;
      repeat (HALF) @(negedge clk);
      if (doneCnt > 0) break;
      if (!expectConv && i >= 40) break;
    end
    csN = 1'b1;
    repeat (10) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(sampleActive == 0 && convStart == 0 && convBusy == 0, "R1 phase flags", int'(sampleActive), 0);
    chk(convClkEn == 0 && convDone == 0, "R1 enables", int'(convClkEn), 0);
    chk(channel == 0, "R1 channel", int'(channel), 0);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    chk(sampleActive == 0 && convBusy == 0, "R1 after release", int'(convBusy), 0);

    for (int code = 0; code < 16; code++) begin
      for (int lng = 0; lng < 2; lng++) begin
        for (int src = 0; src < 4; src++) begin
          if (!isConv(code) && (lng != 0 || src != 0)) continue;
          runFrame(code, lng, src, 16, isConv(code));
          if (isConv(code)) begin
            int win;
            int divr;
            win = (lng != 0) ? 24 : 12;
            divr = (src == 1) ? 1 : (src == 2) ? 4 : 2;
            chk(sampleEdge == 4, "R2 window opens on 4th edge", sampleEdge, 4);
            chk(channel == code[3:0], "R2 channel latched", int'(channel), code);
            if (lng == 0) chk(startEdge == 4 + win, "R4 short window end", startEdge, 4 + win);
            else          chk(startEdge == 4 + win, "R5 long window end", startEdge, 4 + win);
            chk(startCnt == 1, "R6 single convStart", startCnt, 1);
            chk(tickSeen == 12, "R11 enable count", tickSeen, 12);
            chk(doneCnt == 1, "R11 done pulses", doneCnt, 1);
            chk(convBusy == 0 && sampleActive == 0, "R11 idle after done", int'(convBusy), 0);
            if (src == 1) chk(doneEdge - startEdge == 12, "R7 sclk source span", doneEdge - startEdge, 12);
            if (src == 2) chk(doneEdge - startEdge == 48, "R8 sclk/4 source span", doneEdge - startEdge, 48);
            if (src == 3) chk(doneEdge - startEdge == 24, "R9 sclk/2 source span", doneEdge - startEdge, 24);
            if (src == 0) chk(doneEdge - startEdge < 12, "R10 oscillator paced", doneEdge - startEdge, 11);
          end else begin
            chk(sampleSeen == 0, "R3 no window", sampleSeen, 0);
            chk(startCnt == 0 && tickSeen == 0, "R3 no conversion", startCnt, 0);
          end
        end
      end
    end

    // R12: chip select raised after 8 bits closes the window
    runFrame(6, 1, 1, 8, 1'b0);
    chk(sampleSeen == 1, "R12 window had opened", sampleSeen, 1);
    chk(startCnt == 0, "R12 no convStart after abort", startCnt, 0);
    chk(sampleActive == 0 && convBusy == 0, "R12 idle after abort", int'(sampleActive), 0);
    // recovery frame
    runFrame(12, 0, 3, 16, 1'b1);
    chk(startEdge == 16, "R12 next frame works", startEdge, 16);
    chk(channel == 4'd12, "R12 next frame channel", int'(channel), 12);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (195000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule